// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 18-bit words. Its write side and read side each have their own clock and an active-low enable. The two clocks may be one shared clock or two unrelated clocks. Words enter at write-clock edges while the write enable is low. Words leave through a registered read port at read-clock edges while the read enable is low. The read data bus goes to high impedance when the output enable is high.

The buffer reports its fill level through five status outputs: empty, full, half full, almost empty and almost full. The almost flags compare the fill level against two offsets held in a threshold register. Software loads that register through the write side. A rewind input moves the read pointer back to the first word written since reset, so that stored data can be read again.

The pointers cross between the clock domains as Gray code through two-flop synchronizers. Full, half full and almost full are computed in the write domain. Empty and almost empty are computed in the read domain. Depth is `2**ADDR_W` entries, set by a parameter.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: When `wr_en_n` is low at a `wr_clk` edge and `full` is low, `wr_data` is stored at that edge. Words are accepted one per edge for as long as the enable stays low. They are returned in the order they were written.
- R2: When `rd_en_n` is low, `empty` is low and `rewind` is low at a `rd_clk` edge, the oldest unread word is placed in the read data register at that edge. In every other cycle the read data register keeps its value.
- R3: A write attempted while `full` is high, or a read attempted while `empty` is high, is ignored: the pointer does not move and no data is stored or delivered.
- R4: The write pointer crosses into the read domain as Gray code, changing at most one bit per edge. `empty` is a register in the read domain. It is high exactly when the read pointer equals the write pointer seen through two read-clock flops. With a shared clock, a write at edge n first clears `empty` at edge n+3.
- R5: `full` is a register in the write domain. It is high when the write pointer minus the read pointer seen through two write-clock flops equals the depth. With a shared clock, a read at edge n first lowers `full` at edge n+3.
- R6: `half_full` is high when the write-domain count is greater than half the depth.
- R7: `almost_empty` is high when the read-domain count is less than or equal to the empty offset. `almost_full` is high when the write-domain count is greater than or equal to the depth minus the full offset.
- R8: Both offsets are 7 after reset. When `thr_load` is high at a `wr_clk` edge, `thr_empty_off` and `thr_full_off` are loaded. The flags use the new offsets from the next edge onward.
- R9: When `rewind` is high at a `rd_clk` edge, the read pointer returns to the first word written since reset (pointer value 0). A read requested in the same cycle is ignored, and the flags are recomputed from the new pointer. Rewind is meant for use while at most the depth has been written since reset and the write side is idle.
- R10: When `oe_n` is high, `rd_data` is high impedance. When `oe_n` is low, `rd_data` drives the read data register.
- R11: `rst_n` is synchronous and active low, and must be held across edges of both clocks. Reset sets the following state:
  - pointers cleared;
  - `empty` and `almost_empty` high;
  - `full`, `half_full` and `almost_full` low;
  - read data register 0;
  - both offsets 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous reset, active low, seen by both clocks |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| rewind | input | 1 | Return the read pointer to the first stored word |
| oe_n | input | 1 | Output enable for `rd_data`, active low |
| thr_load | input | 1 | Load both offsets (write clock) |
| thr_empty_off | input | ADDR_W | Almost-empty offset to load |
| thr_full_off | input | ADDR_W | Almost-full offset to load |
| rd_data | output | DATA_W | Read data register, high impedance when `oe_n` is high |
| empty | output | 1 | No word available (read domain) |
| full | output | 1 | Depth words held (write domain) |
| half_full | output | 1 | More than half the depth held (write domain) |
| almost_empty | output | 1 | Read-domain count at or below the empty offset |
| almost_full | output | 1 | Write-domain count at or above depth minus the full offset |

## Verification
Two pairs of functions can fall in the same cycle. The first is a rewind and a read request at one edge. The bench raises both together after part of the stored data has been consumed, and expects the read to be dropped with `rd_data` held. It then expects the replay to start at the first word. The second is a write and a read at one edge. Long streams with both enables low, plus a stretch of random traffic, are compared every clock against a behavioural queue model. That model tracks both pointers and the three-edge flag latency with a shared clock.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray code back to binary by prefix XOR.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int s = 1; s < 32; s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int DW = 18,
    parameter int AW = 5
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdat_d, rdat_q;

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    always_comb begin
        rdat_d = rdat_q;
        if (rd_en) rdat_d = mem_q[rd_addr];
    end

    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) rdat_q <= '0;
        else           rdat_q <= rdat_d;
    end

    assign rd_q = rdat_q;
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside
    import xfifo_pkg::*;
#(
    parameter int AW      = 5,
    parameter int DEF_OFF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req_n,
    input  logic          ld,
    input  logic [AW-1:0] ae_in,
    input  logic [AW-1:0] af_in,
    input  logic [AW:0]   rgray_sync,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wgray,
    output logic          wr_fire,
    output logic          full,
    output logic          afull,
    output logic          hfull,
    output logic [AW-1:0] ae_off
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;
    localparam logic [PW-1:0] HALF_P  = DEPTH_P >> 1;
    localparam logic [AW-1:0] DEF_P   = AW'(DEF_OFF);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
        logic          hfull;
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
    } wst_t;

    wst_t st_d, st_q;
    logic [PW-1:0] rbin, cnt;

    always_comb begin
        st_d    = st_q;
        wr_fire = !push_req_n && !st_q.full;
        rbin    = PW'(from_gray(32'(rgray_sync)));
        st_d.bin  = st_q.bin + PW'(wr_fire);
        st_d.gray = PW'(to_gray(32'(st_d.bin)));
        cnt        = st_d.bin - rbin;
        st_d.full  = (cnt == DEPTH_P);
        st_d.afull = (cnt >= (DEPTH_P - PW'(st_q.af)));
        st_d.hfull = (cnt > HALF_P);
        if (ld) begin
            st_d.ae = ae_in;
            st_d.af = af_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{bin: '0, gray: '0, full: 1'b0, afull: 1'b0, hfull: 1'b0,
                      ae: DEF_P, af: DEF_P};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr = st_q.bin[AW-1:0];
    assign wgray   = st_q.gray;
    assign full    = st_q.full;
    assign afull   = st_q.afull;
    assign hfull   = st_q.hfull;
    assign ae_off  = st_q.ae;

    // A write offered while full leaves the write pointer in place.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !push_req_n) |=> (st_q.bin == $past(st_q.bin)));

    // Full implies the weaker write-side levels.
    assert_full_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> (st_q.afull && st_q.hfull));

    // The crossing pointer changes at most one bit per edge.
    assert_wgray_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(st_q.gray ^ $past(st_q.gray)) <= 1));
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside
    import xfifo_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_req_n,
    input  logic          rewind,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW-1:0] ae_off,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rgray,
    output logic          rd_fire,
    output logic          empty,
    output logic          aempty
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic          aempty;
    } rst_t;

    rst_t st_d, st_q;
    logic [PW-1:0] wbin, cnt;

    always_comb begin
        st_d    = st_q;
        rd_fire = !pop_req_n && !st_q.empty && !rewind;
        wbin    = PW'(from_gray(32'(wgray_sync)));
        if (rewind) st_d.bin = '0;
        else        st_d.bin = st_q.bin + PW'(rd_fire);
        st_d.gray   = PW'(to_gray(32'(st_d.bin)));
        cnt         = wbin - st_d.bin;
        st_d.empty  = (cnt == '0);
        st_d.aempty = (cnt <= PW'(ae_off));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, empty: 1'b1, aempty: 1'b1};
        else        st_q <= st_d;
    end

    assign rd_addr = st_q.bin[AW-1:0];
    assign rgray   = st_q.gray;
    assign empty   = st_q.empty;
    assign aempty  = st_q.aempty;

    // A read offered while empty leaves the read pointer in place.
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.empty && !pop_req_n && !rewind) |=> (st_q.bin == $past(st_q.bin)));

    // Rewind lands on the first stored word.
    assert_rewind_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (st_q.bin == '0));

    // Empty implies almost empty.
    assert_empty_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.empty |-> st_q.aempty);
endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo #(
    parameter int DATA_W  = 18,
    parameter int ADDR_W  = 5,
    parameter int DEF_OFF = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    input  logic              rewind,
    input  logic              oe_n,
    input  logic              thr_load,
    input  logic [ADDR_W-1:0] thr_empty_off,
    input  logic [ADDR_W-1:0] thr_full_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [ADDR_W-1:0] wr_addr, rd_addr, ae_off;
    logic              wr_fire, rd_fire;
    logic [DATA_W-1:0] ram_q;

    xfifo_wside #(.AW(ADDR_W), .DEF_OFF(DEF_OFF)) u_wside (
        .clk(wr_clk), .rst_n(rst_n), .push_req_n(wr_en_n), .ld(thr_load),
        .ae_in(thr_empty_off), .af_in(thr_full_off), .rgray_sync(rgray_s),
        .wr_addr(wr_addr), .wgray(wgray), .wr_fire(wr_fire), .full(full),
        .afull(almost_full), .hfull(half_full), .ae_off(ae_off)
    );

    xfifo_rside #(.AW(ADDR_W)) u_rside (
        .clk(rd_clk), .rst_n(rst_n), .pop_req_n(rd_en_n), .rewind(rewind),
        .wgray_sync(wgray_s), .ae_off(ae_off), .rd_addr(rd_addr), .rgray(rgray),
        .rd_fire(rd_fire), .empty(empty), .aempty(almost_empty)
    );

    // Write pointer into the read domain, read pointer into the write domain.
    xfifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    xfifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    xfifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
        .wr_clk(wr_clk), .wr_en(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_en(rd_fire), .rd_addr(rd_addr),
        .rd_q(ram_q)
    );

    assign rd_data = oe_n ? {DATA_W{1'bz}} : ram_q;

    // Without an accepted read, the read data register holds.
    assert_hold_rdata_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en_n || empty || rewind) |=> $stable(ram_q));
endmodule

// File: tb/sim_dual_clock_flag_fifo.sv
module sim_dual_clock_flag_fifo;
    localparam int DW = 18;
    localparam int AW = 5;
    localparam int D  = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0, wr_en_n = 1'b1, rd_en_n = 1'b1;
    logic          rewind = 1'b0, oe_n = 1'b0, thr_load = 1'b0;
    logic [AW-1:0] thr_ae = '0, thr_af = '0;
    logic [DW-1:0] wr_data = '0;
    wire  [DW-1:0] rd_data;
    logic          empty, full, half_full, almost_empty, almost_full;

    dual_clock_flag_fifo u0 (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .wr_data(wr_data), .rd_en_n(rd_en_n), .rewind(rewind), .oe_n(oe_n),
        .thr_load(thr_load), .thr_empty_off(thr_ae), .thr_full_off(thr_af),
        .rd_data(rd_data), .empty(empty), .full(full), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    // Behavioural model: unbounded pointer counts plus three-edge histories.
    int mW, mR, w1, w2, w3, r1, r2, r3, e_rd, m_ae, m_af;
    int mem_m [D];
    bit e_empty, e_full, e_hf, e_ae, e_af;
    int total = 0, fails = 0;
    bit done = 0;
    string dtag = "R2";

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit push, pop;
        int wc, rc;
        if (!rst_n) begin
            mW = 0; mR = 0; w1 = 0; w2 = 0; w3 = 0; r1 = 0; r2 = 0; r3 = 0;
            m_ae = 7; m_af = 7; e_rd = 0;
            e_empty = 1; e_ae = 1; e_full = 0; e_hf = 0; e_af = 0;
        end else begin
            push = !wr_en_n && !e_full;
            pop  = !rd_en_n && !e_empty && !rewind;
            if (push) mem_m[mW % D] = int'(wr_data);
            if (pop)  e_rd = mem_m[mR % D];
            w3 = w2; w2 = w1; w1 = mW; mW = mW + int'(push);
            r3 = r2; r2 = r1; r1 = mR; mR = rewind ? 0 : mR + int'(pop);
            wc = mW - r3;
            rc = w3 - mR;
            e_full  = (wc == D);
            e_af    = (wc >= D - m_af);
            e_hf    = (wc > D / 2);
            e_empty = (rc == 0);
            e_ae    = (rc <= m_ae);
            if (thr_load) begin
                m_ae = int'(thr_ae);
                m_af = int'(thr_af);
            end
        end
    endtask

    task automatic compare();
        chk("R4 empty", int'(empty), int'(e_empty));
        chk("R5 full", int'(full), int'(e_full));
        chk("R6 half_full", int'(half_full), int'(e_hf));
        chk("R7 almost_empty", int'(almost_empty), int'(e_ae));
        chk("R7 almost_full", int'(almost_full), int'(e_af));
        if (!oe_n) begin
            chk({dtag, " rd_data"}, int'(rd_data), e_rd);
        end else begin
            total++;
            if (!(rd_data === {DW{1'bz}} || rd_data == '0)) begin
                fails++;
                $display("FAIL R10 rd_data not floating: actual %0d expected high impedance",
                         rd_data);
            end
        end
    endtask

    // Model the coming edge from the inputs now applied, then check after it.
    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        chk("R11 empty after reset", int'(empty), 1);
        chk("R11 almost_empty after reset", int'(almost_empty), 1);
        chk("R11 full after reset", int'(full), 0);
        chk("R11 half_full after reset", int'(half_full), 0);
        chk("R11 almost_full after reset", int'(almost_full), 0);
        chk("R11 rd_data after reset", int'(rd_data), 0);

        // Short burst in, then out.
        dtag = "R1";
        for (int i = 0; i < 5; i++) begin
            wr_en_n = 1'b0; wr_data = DW'(18'h20000 + i); step();
        end
        wr_en_n = 1'b1;
        repeat (4) step();
        rd_en_n = 1'b0; repeat (5) step(); rd_en_n = 1'b1;
        repeat (4) step();
        chk("R1 last word in order", int'(rd_data), 'h20004);

        // Reads on an empty buffer.
        dtag = "R3";
        rd_en_n = 1'b0; repeat (3) step(); rd_en_n = 1'b1;
        step();
        chk("R3 read on empty holds data", int'(rd_data), 'h20004);

        // Overfill, then drain.
        for (int i = 0; i < 40; i++) begin
            wr_en_n = 1'b0; wr_data = DW'(18'h10000 + 3 * i); step();
        end
        wr_en_n = 1'b1;
        repeat (4) step();
        chk("R5 full after overfill", int'(full), 1);
        chk("R6 half_full when full", int'(half_full), 1);
        rd_en_n = 1'b0; repeat (40) step(); rd_en_n = 1'b1;
        repeat (4) step();
        chk("R3 writes beyond full dropped", int'(rd_data), 'h10000 + 3 * 31);
        chk("R4 empty after drain", int'(empty), 1);

        // Simultaneous write and read streams.
        dtag = "R2";
        for (int i = 0; i < 30; i++) begin
            wr_en_n = 1'b0; rd_en_n = 1'b0; wr_data = DW'(18'h05000 + 7 * i); step();
        end
        wr_en_n = 1'b1;
        repeat (40) step();
        rd_en_n = 1'b1;
        repeat (4) step();

        // Threshold load.
        thr_load = 1'b1; thr_ae = AW'(3); thr_af = AW'(2); step();
        thr_load = 1'b0; thr_ae = '0; thr_af = '0;
        for (int i = 0; i < 4; i++) begin
            wr_en_n = 1'b0; wr_data = DW'(18'h01100 + i); step();
        end
        wr_en_n = 1'b1;
        repeat (4) step();
        chk("R8 almost_empty uses loaded offset", int'(almost_empty), 0);
        for (int i = 0; i < 25; i++) begin
            wr_en_n = 1'b0; wr_data = DW'(18'h01200 + i); step();
        end
        wr_en_n = 1'b1;
        repeat (4) step();
        chk("R8 almost_full off at depth minus 3", int'(almost_full), 0);
        wr_en_n = 1'b0; wr_data = DW'(18'h01300); step(); wr_en_n = 1'b1;
        repeat (4) step();
        chk("R8 almost_full on at depth minus 2", int'(almost_full), 1);

        // Output enable.
        rd_en_n = 1'b0; step(); rd_en_n = 1'b1;
        oe_n = 1'b1; step(); step();
        oe_n = 1'b0; step();
        chk("R10 rd_data driven again", int'(rd_data), 'h01100);

        // Rewind together with a read request.
        do_reset();
        for (int i = 0; i < 10; i++) begin
            wr_en_n = 1'b0; wr_data = DW'(18'h30000 + i); step();
        end
        wr_en_n = 1'b1;
        repeat (4) step();
        rd_en_n = 1'b0; repeat (6) step(); rd_en_n = 1'b1;
        repeat (2) step();
        dtag = "R9";
        rewind = 1'b1; rd_en_n = 1'b0; step();
        rewind = 1'b0; rd_en_n = 1'b1;
        chk("R9 read ignored during rewind", int'(rd_data), 'h30005);
        repeat (4) step();
        chk("R9 not empty after rewind", int'(empty), 0);
        rd_en_n = 1'b0; step();
        chk("R9 replay starts at first word", int'(rd_data), 'h30000);
        repeat (9) step(); rd_en_n = 1'b1;
        repeat (4) step();
        chk("R9 replay ends at last word", int'(rd_data), 'h30009);
        chk("R9 empty after replay", int'(empty), 1);

        // Random mixed traffic.
        dtag = "R2";
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            wr_en_n = ($urandom % 3) == 0;
            rd_en_n = ($urandom % 3) == 0;
            wr_data = DW'($urandom);
            step();
        end
        wr_en_n = 1'b1; rd_en_n = 1'b1;
        repeat (4) step();

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule